// File: doc/BRIEF.md
# Serial Receive Byte Buffer with Trigger and Idle Timeout

This block holds the bytes that a serial controller's line receiver delivers before the host reads them. Each accepted byte from the line side goes into a 16-entry first-in first-out store. Each host read of the data register takes the oldest byte out. The block keeps five status flags: empty, full, trigger level reached, overflow and idle timeout. It also gives a one-cycle event pulse on each flag's rising edge, so that an interrupt register can capture it.

Receive is enabled only while the enable control is high and the disable control is low. A reset command clears the receive state. A detected line break is stored as a zero byte. The idle timeout fires when four character times pass without an accepted byte. The character time is given in clock cycles by the serial timing logic.

Top module: `serial_rx_buffer`

## Requirements
- R1: Bytes are read out in the order they were accepted. The store holds up to 16 bytes, counted by a 5-bit occupancy. `rd_data` is updated on the clock edge that samples `rd_req`, and holds its value until the next read.
- R2: Pushes and reads take effect only when `rx_en`=1 and `rx_dis`=0. Otherwise a push is ignored, and a read returns 0x00 without removing a byte or changing any flag.
- R3: A push while 16 bytes are held discards the byte and sets `st_ovr`.
- R4: `st_full` is high exactly while 16 bytes are held.
- R5: A push that leaves the count at or above the trigger level sets `st_trig`. A read that leaves the count below the level clears it. The level is written through `trig_we`/`trig_wdata` and resets to 32, so by default the flag never sets at depth 16.
- R6: Every enabled read clears `st_full` and `st_ovr`. A read that leaves the store empty sets `st_empty`, and any enabled push clears it. Within one cycle, a set condition wins over a clear.
- R7: An enabled read of an empty store returns 0x00 and leaves `st_empty` high.
- R8: Each accepted push restarts an idle timer. If no further byte is accepted, `st_tout` goes high exactly 4×`char_ticks` cycles after the edge that accepted the push.
- R9: `rx_reset` empties the store, sets `st_empty`, clears `st_full`, `st_ovr` and `st_tout`, and cancels the idle timer. It takes priority over a push or read in the same cycle. It does not change `st_trig`.
- R10: `line_break` pushes the byte 0x00. When it coincides with `line_valid`, the zero byte is stored and `line_byte` is dropped.
- R11: Each `ev_*` output is high for one cycle, in the first cycle its flag is high after having been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable control |
| rx_dis | input | 1 | Receive disable control, overrides enable |
| rx_reset | input | 1 | Receive reset command, one cycle |
| char_ticks | input | 16 | Character time in clock cycles |
| trig_we | input | 1 | Write strobe for the trigger level |
| trig_wdata | input | 6 | New trigger level |
| line_valid | input | 1 | A received byte is present on `line_byte` |
| line_byte | input | 8 | Received byte |
| line_break | input | 1 | Line break detected, one cycle |
| rd_req | input | 1 | Host read of the data register |
| rd_data | output | 8 | Byte returned by the last read |
| st_empty | output | 1 | Store empty |
| st_full | output | 1 | Store full |
| st_trig | output | 1 | Trigger level reached |
| st_ovr | output | 1 | Byte lost to overflow |
| st_tout | output | 1 | Idle timeout reached |
| ev_empty | output | 1 | Rising event of `st_empty` |
| ev_full | output | 1 | Rising event of `st_full` |
| ev_trig | output | 1 | Rising event of `st_trig` |
| ev_ovr | output | 1 | Rising event of `st_ovr` |
| ev_tout | output | 1 | Rising event of `st_tout` |

## Verification
The occupancy count is not brought out, so a wrong count or pointer has to show up as a wrong byte on the next read, or as a flag that toggles at the wrong fill level. For that reason the bench drains every byte it writes and compares each value read. Timer faults are checked to the exact cycle by sampling one cycle before and one cycle after the expected expiry. Ignored stimulus, such as disabled pushes and reads, or a byte lost under a break, is checked by reading back through the data port before any other operation.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // Status flags of the receive buffer, one bit each
  typedef struct packed {
    logic tout;
    logic ovr;
    logic trig;
    logic full;
    logic empty;
  } rxb_flags_t;

  localparam rxb_flags_t RXB_FLAGS_RESET = '{tout: 1'b0, ovr: 1'b0, trig: 1'b0,
                                             full: 1'b0, empty: 1'b1};

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_ok,
  input  logic              pop_ok,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nxt
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  // Occupancy after one cycle of pushes and pops
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    logic [CNT_W-1:0] r;
    r = c;
    if (up && !dn) r = c + 1'b1;
    if (dn && !up) r = c - 1'b1;
    return r;
  endfunction

  // Pointer advance with wrap at the last entry
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign count_nxt = cnt_step(count, push_ok, pop_ok);
  assign head      = mem[rptr];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (push_ok && !clr && wptr == PTR_W'(g)) mem[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_step(wptr);
      if (pop_ok)  rptr <= ptr_step(rptr);
      count <= count_nxt;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);  // R1
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_ok && !pop_ok && count == CNT_FULL));  // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);  // R9

endmodule

// File: rtl/rxb_timer.sv
module rxb_timer #(
  parameter int TICK_W = 16,
  parameter int SPAN_W = TICK_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              restart,
  input  logic [TICK_W-1:0] char_ticks,
  output logic              expire
);

  logic [SPAN_W-1:0] remain;
  logic              run;

  // Idle window: four character times
  function automatic logic [SPAN_W-1:0] idle_span(input logic [TICK_W-1:0] t);
    return {t, 2'b00};
  endfunction

  assign expire = run && (remain <= SPAN_W'(1)) && !restart && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      remain <= '0;
    end else if (clr) begin
      run    <= 1'b0;
      remain <= '0;
    end else if (restart) begin
      run    <= 1'b1;
      remain <= idle_span(char_ticks);
    end else if (run) begin
      if (remain <= SPAN_W'(1)) run <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

  AST_TIMER_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !run);  // R9
  AST_RESTART_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !clr) |=> run);  // R8

endmodule

// File: rtl/rxb_flags.sv
module rxb_flags
  import rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH) + 1,
  parameter int LVL_W = $clog2(DEPTH) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_try,
  input  logic             push_ok,
  input  logic             pop_try,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [LVL_W-1:0] level,
  input  logic             expire,
  output rxb_flags_t       cur,
  output rxb_flags_t       ev
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  rxb_flags_t nxt;

  function automatic logic at_level(input logic [CNT_W-1:0] c,
                                    input logic [LVL_W-1:0] l);
    return {{(LVL_W-CNT_W){1'b0}}, c} >= l;
  endfunction

  always_comb begin
    nxt = cur;
    if (clr) begin
      nxt.empty = 1'b1;
      nxt.full  = 1'b0;
      nxt.ovr   = 1'b0;
      nxt.tout  = 1'b0;
    end else begin
      if (push_try || pop_try) nxt.empty = (count_nxt == '0);
      if (pop_try) begin
        nxt.full = 1'b0;
        nxt.ovr  = 1'b0;
        if (!at_level(count_nxt, level)) nxt.trig = 1'b0;
      end
      if (push_ok && count_nxt == CNT_FULL)        nxt.full = 1'b1;
      if (push_try && count == CNT_FULL)           nxt.ovr  = 1'b1;
      if (push_ok && at_level(count_nxt, level))   nxt.trig = 1'b1;
      if (expire)                                  nxt.tout = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= RXB_FLAGS_RESET;
      ev  <= '0;
    end else begin
      cur <= nxt;
      ev  <= nxt & ~cur;
    end
  end

  AST_FULL_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cur.full == (count == CNT_FULL));  // R4
  AST_OVR_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_try && count == CNT_FULL && !clr) |=> cur.ovr);  // R3
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cur.empty && !cur.full && !cur.ovr && !cur.tout);  // R9
  AST_EV_TOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev.tout |-> cur.tout && !$past(cur.tout));  // R11
  AST_EV_OVR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ev.ovr |-> cur.ovr && !$past(cur.ovr));  // R11

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import rxb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 8,
  parameter int TICK_W     = 16,
  parameter int LVL_W      = $clog2(DEPTH) + 2,
  parameter int TRIG_RESET = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_dis,
  input  logic              rx_reset,
  input  logic [TICK_W-1:0] char_ticks,
  input  logic              trig_we,
  input  logic [LVL_W-1:0]  trig_wdata,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_byte,
  input  logic              line_break,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_empty,
  output logic              st_full,
  output logic              st_trig,
  output logic              st_ovr,
  output logic              st_tout,
  output logic              ev_empty,
  output logic              ev_full,
  output logic              ev_trig,
  output logic              ev_ovr,
  output logic              ev_tout
);

  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic              rx_on;
  logic              push_try, pop_try, push_ok, pop_ok;
  logic [DATA_W-1:0] wbyte, head;
  logic [CNT_W-1:0]  count, count_nxt;
  logic [LVL_W-1:0]  level;
  logic              expire;
  rxb_flags_t        flg, evt;

  assign rx_on    = rx_en && !rx_dis;
  assign wbyte    = line_break ? '0 : line_byte;
  assign push_try = (line_valid || line_break) && rx_on && !rx_reset;
  assign pop_try  = rd_req && rx_on && !rx_reset;
  assign push_ok  = push_try && (count != CNT_FULL);
  assign pop_ok   = pop_try && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       level <= LVL_W'(TRIG_RESET);
    else if (trig_we) level <= trig_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= pop_ok ? head : '0;
  end

  rxb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n, .clr(rx_reset), .push_ok, .pop_ok, .wdata(wbyte),
    .head, .count, .count_nxt
  );

  rxb_timer #(.TICK_W(TICK_W)) u_timer (
    .clk, .rst_n, .clr(rx_reset), .restart(push_ok), .char_ticks, .expire
  );

  rxb_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
    .clk, .rst_n, .clr(rx_reset), .push_try, .push_ok, .pop_try,
    .count, .count_nxt, .level, .expire, .cur(flg), .ev(evt)
  );

  assign st_empty = flg.empty;
  assign st_full  = flg.full;
  assign st_trig  = flg.trig;
  assign st_ovr   = flg.ovr;
  assign st_tout  = flg.tout;
  assign ev_empty = evt.empty;
  assign ev_full  = evt.full;
  assign ev_trig  = evt.trig;
  assign ev_ovr   = evt.ovr;
  assign ev_tout  = evt.tout;

  AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rx_on) |=> rd_data == '0);  // R2
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !rx_reset) |=> $stable(count));  // R2
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_try && count == '0) |=> rd_data == '0 && st_empty);  // R7

endmodule

// File: tb/test_serial_rx_buffer.sv
`timescale 1ns/100ps
module test_serial_rx_buffer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1, rx_dis = 1'b0, rx_reset = 1'b0;
  logic [15:0] char_ticks = 16'd1000;
  logic       trig_we = 1'b0;
  logic [5:0] trig_wdata = '0;
  logic       line_valid = 1'b0, line_break = 1'b0, rd_req = 1'b0;
  logic [7:0] line_byte = '0;
  logic [7:0] rd_data;
  logic st_empty, st_full, st_trig, st_ovr, st_tout;
  logic ev_empty, ev_full, ev_trig, ev_ovr, ev_tout;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  serial_rx_buffer i_serial_rx_buffer (.*);

  // op: 0 push, 1 read, 2 break; fields {op, din, exp_rd, {empty,full,trig,ovr}}
  localparam logic [21:0] VEC [11] = '{
    {2'd0, 8'h11, 8'h00, 4'b0000},
    {2'd0, 8'h22, 8'h00, 4'b0000},
    {2'd0, 8'h33, 8'h00, 4'b0010},
    {2'd2, 8'h00, 8'h00, 4'b0010},
    {2'd1, 8'h00, 8'h11, 4'b0010},
    {2'd1, 8'h00, 8'h22, 4'b0000},
    {2'd1, 8'h00, 8'h33, 4'b0000},
    {2'd1, 8'h00, 8'h00, 4'b1000},
    {2'd1, 8'h00, 8'h00, 4'b1000},
    {2'd0, 8'h5A, 8'h00, 4'b0000},
    {2'd1, 8'h00, 8'h5A, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); line_valid = 1'b1; line_byte = b;
    @(negedge clk); line_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk); line_break = 1'b1;
    @(negedge clk); line_break = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic rxrst();
    @(negedge clk); rx_reset = 1'b1;
    @(negedge clk); rx_reset = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R6 reset empty", st_empty, 1);
    chk("R9 reset other flags", {st_full, st_trig, st_ovr, st_tout}, 0);
    chk("R11 reset events", {ev_empty, ev_full, ev_trig, ev_ovr, ev_tout}, 0);
    chk("R1 reset rd_data", rd_data, 0);

    // Fill with default trigger level 32: never triggers (R5)
    for (int i = 0; i < 16; i++) push(8'hC0 + 8'(i));
    chk("R4 full at 16", st_full, 1);
    chk("R11 ev_full pulse", ev_full, 1);
    chk("R5 default level no trig", st_trig, 0);
    @(negedge clk);
    chk("R11 ev_full one cycle", ev_full, 0);
    push(8'hEE);
    chk("R3 overflow set", st_ovr, 1);
    chk("R11 ev_ovr pulse", ev_ovr, 1);
    chk("R4 still full", st_full, 1);
    rd();
    chk("R1 oldest first", rd_data, 8'hC0);
    chk("R6 read clears full/ovr", {st_full, st_ovr}, 0);
    for (int i = 1; i < 16; i++) begin
      rd();
      chk("R1 order", rd_data, 8'hC0 + 8'(i));
    end
    chk("R3 dropped byte absent: empty", st_empty, 1);
    rd();
    chk("R7 empty read zero", rd_data, 0);
    chk("R7 empty flag", st_empty, 1);

    // Table walk with trigger level 3
    @(negedge clk); trig_we = 1'b1; trig_wdata = 6'd3;
    @(negedge clk); trig_we = 1'b0;
    for (int k = 0; k < 11; k++) begin
      case (VEC[k][21:20])
        2'd0: push(VEC[k][19:12]);
        2'd1: rd();
        default: brk();
      endcase
      if (VEC[k][21:20] == 2'd1) chk("R1 R10 table read", rd_data, 32'(VEC[k][11:4]));
      chk("R5 R6 table flags", {st_empty, st_full, st_trig, st_ovr}, 32'(VEC[k][3:0]));
      if (k == 2) chk("R11 ev_trig", ev_trig, 1);
    end

    // Disable gating (R2)
    push(8'h77);
    rx_dis = 1'b1;
    push(8'h88);
    rd();
    chk("R2 disabled read zero", rd_data, 0);
    chk("R2 disabled no flag change", st_empty, 0);
    rx_dis = 1'b0; rx_en = 1'b0;
    push(8'h99);
    rx_en = 1'b1;
    rd();
    chk("R2 byte kept across disabled read", rd_data, 8'h77);
    rd();
    chk("R2 disabled pushes dropped", {st_empty, 8'(rd_data)}, {1'b1, 8'h00});

    // Break together with a byte (R10)
    @(negedge clk); line_valid = 1'b1; line_byte = 8'hAB; line_break = 1'b1;
    @(negedge clk); line_valid = 1'b0; line_break = 1'b0;
    push(8'h44);
    rd();
    chk("R10 break stores zero", rd_data, 0);
    rd();
    chk("R10 coincident byte dropped", rd_data, 8'h44);

    // Receive reset (R9)
    push(8'h12); push(8'h34);
    rxrst();
    chk("R9 reset flags", {st_empty, st_full, st_ovr, st_tout}, 4'b1000);
    rd();
    chk("R9 store emptied", rd_data, 0);

    // Idle timeout, span 4*5 = 20 cycles (R8)
    char_ticks = 16'd5;
    push(8'h01);
    repeat (9) @(negedge clk);
    push(8'h02);
    repeat (18) @(negedge clk);
    chk("R8 restart delays timeout", st_tout, 0);
    @(negedge clk);
    chk("R8 not before 20 cycles", st_tout, 0);
    @(negedge clk);
    chk("R8 timeout at 20 cycles", st_tout, 1);
    chk("R11 ev_tout", ev_tout, 1);
    @(negedge clk);
    chk("R11 ev_tout one cycle", ev_tout, 0);
    rxrst();
    chk("R9 timeout cleared", st_tout, 0);
    repeat (30) @(negedge clk);
    chk("R9 timer cancelled", st_tout, 0);

    finish_run();
  end

endmodule